// File: doc/BRIEF.md
# Serial-Load Latched DAC Register

This block is the digital front end of a 10-bit voltage-output converter. A host lowers an active-low load input, then presents one bit at a time on a serial data pin. Each rising edge of a serial clock captures one bit, least-significant bit first. When the tenth bit arrives, the assembled word is copied into an output holding register in the same step. The block then locks itself out and ignores all serial traffic until the load input is raised and lowered again. A partial word that is cut short by releasing the load input is thrown away.

The serial pins are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and serial-clock rising edges are detected in the system-clock domain. The system clock must therefore run at least four times faster than the serial clock. The held code is two's complement: 1000000000 is zero scale, 0000000000 is mid scale and 0111111111 is full scale. The block also drives an offset-binary copy of the code for the converter core, a one-cycle update strobe, and a synchronized power-down status. The power-down status has no effect on loading.

Top module: `sdac_loader`

## Requirements
- R1: After reset, code_o is 0000000000 (mid scale), obin_o is 512, upd_o is 0, and the first selection accepts a full word.
- R2: While load_n is low, each rising edge of ser_clk shifts in the ser_dat bit, least-significant bit first. After the tenth rising edge, code_o equals the ten received bits, with the first bit received at bit 0.
- R3: upd_o is high for exactly one system-clock cycle for each load. code_o changes only in a cycle where upd_o is high.
- R4: After a load, further ser_clk edges and ser_dat values are ignored until load_n goes high and then low again.
- R5: While load_n is high, ser_clk edges neither shift data nor advance the bit count, and code_o keeps its value.
- R6: If load_n rises before ten bits have arrived, the partial word is discarded and code_o is unchanged. The next selection starts again from bit 0.
- R7: obin_o equals code_o with bit 9 inverted. Zero scale (1000000000) gives 0, full scale (0111111111) gives 1023, and mid scale gives 512.
- R8: pwrdn_o follows pwrdn_req after two system-clock cycles, and a high pwrdn_req does not prevent a load.
- R9: If the tenth rising edge of ser_clk and the release of load_n reach the block in the same system-clock cycle, the release wins: no load and no strobe occur.
- R10: Falling edges of ser_clk do not shift data. This includes a ser_clk that is already high when load_n falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load_n | input | 1 | Active-low word select (asynchronous) |
| ser_clk | input | 1 | Serial bit clock; bits are taken on rising edges (asynchronous) |
| ser_dat | input | 1 | Serial data, least-significant bit first (asynchronous) |
| pwrdn_req | input | 1 | Power-down request for the converter (asynchronous) |
| code_o | output | 10 | Latched two's-complement code |
| obin_o | output | 10 | Offset-binary copy of the latched code |
| upd_o | output | 1 | One-cycle strobe when the holding register loads |
| pwrdn_o | output | 1 | Synchronized power-down status |

## Verification
The tenth-bit transfer and the select release can land in the same system-clock cycle. They collide because ser_clk and load_n pass through synchronizers of equal depth. The bench provokes this by raising ser_clk and releasing load_n at the same instant after nine bits. It judges the result by the absence of any update strobe and an unchanged code. A second overlap pairs a load with a high power-down request; here the word must still arrive intact while pwrdn_o reads high.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  // Default geometry of the serial word and of the input synchronizers.
  localparam int unsigned WORD_W_DEF  = 10;
  localparam int unsigned SYNC_ST_DEF = 2;

  // Receiver control: armed accepts bits, locked waits for a select release.
  typedef enum logic {
    RX_ARMED  = 1'b0,
    RX_LOCKED = 1'b1
  } rx_state_e;

endpackage

// File: rtl/sdac_rst_sync.sv
module sdac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;

  // Asserts at once, releases after STAGES clock edges.
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int unsigned         W       = 1,
  parameter int unsigned         STAGES  = 2,
  parameter logic        [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[g] <= RST_VAL;
        else        stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/sdac_edge.sv
module sdac_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);

  logic prev_q;

  // prev resets high so a line that is already high after reset is not
  // taken as a rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

endmodule

// File: rtl/sdac_rx.sv
module sdac_rx
  import sdac_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_W_DEF,
  localparam int unsigned CNT_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n_i,
  input  logic              rise_i,
  input  logic              dat_i,
  output logic              load_o,
  output logic [WORD_W-1:0] word_o
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  rx_state_e         state_q, state_n;
  logic [CNT_W-1:0]  cnt_q,   cnt_n;
  logic [WORD_W-2:0] sh_q,    sh_n;
  logic              sh_en;

  // Next-state logic. A high select has priority over everything else.
  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    sh_n    = sh_q;
    sh_en   = 1'b0;
    load_o  = 1'b0;
    if (sel_n_i) begin
      state_n = RX_ARMED;
      cnt_n   = '0;
    end else if (state_q == RX_ARMED && rise_i) begin
      if (cnt_q == LAST_BIT) begin
        load_o  = 1'b1;
        cnt_n   = '0;
        state_n = RX_LOCKED;
      end else begin
        sh_en = 1'b1;
        sh_n  = {dat_i, sh_q[WORD_W-2:1]};
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  // The completed word takes the last bit straight from the data line.
  assign word_o = {dat_i, sh_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_ARMED;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
    end
  end

  // Data path register: no reset, written only when a bit is shifted in.
  always_ff @(posedge clk) begin
    if (sh_en) sh_q <= sh_n;
  end

endmodule

// File: rtl/sdac_hold.sv
module sdac_hold #(
  parameter int unsigned WORD_W = sdac_pkg::WORD_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] code_o,
  output logic [WORD_W-1:0] obin_o,
  output logic              upd_o
);

  logic [WORD_W-1:0] code_q, code_n;
  logic              upd_q;

  always_comb begin
    code_n = code_q;
    if (load_i) code_n = word_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      upd_q  <= 1'b0;
    end else begin
      code_q <= code_n;
      upd_q  <= load_i;
    end
  end

  assign code_o = code_q;
  assign upd_o  = upd_q;
  // Two's complement to offset binary: flip the sign bit.
  assign obin_o = {~code_q[WORD_W-1], code_q[WORD_W-2:0]};

endmodule

// File: rtl/sdac_loader.sv
module sdac_loader #(
  parameter int unsigned WORD_W  = sdac_pkg::WORD_W_DEF,
  parameter int unsigned SYNC_ST = sdac_pkg::SYNC_ST_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              pwrdn_req,
  output logic [WORD_W-1:0] code_o,
  output logic [WORD_W-1:0] obin_o,
  output logic              upd_o,
  output logic              pwrdn_o
);

  localparam int unsigned SER_W = 3;

  logic              rst_n_s;
  logic [SER_W-1:0]  ser_s;
  logic              sel_n_s, sclk_s, sdat_s;
  logic              rise_w;
  logic              load_w;
  logic [WORD_W-1:0] word_w;

  sdac_rst_sync #(.STAGES(SYNC_ST)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  // Select, clock and data share one synchronizer so they stay aligned.
  sdac_sync #(.W(SER_W), .STAGES(SYNC_ST), .RST_VAL(3'b100)) u_ser_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_i   ({load_n, ser_clk, ser_dat}),
    .q_o   (ser_s)
  );

  assign sel_n_s = ser_s[2];
  assign sclk_s  = ser_s[1];
  assign sdat_s  = ser_s[0];

  sdac_sync #(.W(1), .STAGES(SYNC_ST), .RST_VAL(1'b0)) u_pd_sync (
    .clk   (clk),
    .rst_n (rst_n_s),
    .d_i   (pwrdn_req),
    .q_o   (pwrdn_o)
  );

  sdac_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .lvl_i  (sclk_s),
    .rise_o (rise_w)
  );

  sdac_rx #(.WORD_W(WORD_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .sel_n_i (sel_n_s),
    .rise_i  (rise_w),
    .dat_i   (sdat_s),
    .load_o  (load_w),
    .word_o  (word_w)
  );

  sdac_hold #(.WORD_W(WORD_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load_i (load_w),
    .word_i (word_w),
    .code_o (code_o),
    .obin_o (obin_o),
    .upd_o  (upd_o)
  );

endmodule

// File: rtl/sdac_loader_chk.sv
module sdac_loader_chk #(
  parameter int unsigned WORD_W = 10,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_n_s,
  input logic [WORD_W-1:0] code_o,
  input logic              upd_o,
  input logic              locked,
  input logic [CNT_W-1:0]  cnt
);

  // R3: the code only moves together with the strobe
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_o |-> $stable(code_o));

  // R3: the strobe lasts one cycle
  assert_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o);

  // R2: the bit count never reaches the word width
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CNT_W'(WORD_W));

  // R4: a load leaves the receiver locked with a cleared count
  assert_upd_locks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> locked);

  assert_lock_cnt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (cnt == '0));

  // R5: a released select clears the count and the lock
  assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n_s |=> (cnt == '0 && !locked));

  // R9: no load while the select is released
  assert_sel_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n_s |=> !upd_o);

endmodule

bind sdac_loader sdac_loader_chk #(
  .WORD_W (WORD_W),
  .CNT_W  ($clog2(WORD_W))
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n_s),
  .sel_n_s (sel_n_s),
  .code_o  (code_o),
  .upd_o   (upd_o),
  .locked  (u_rx.state_q == sdac_pkg::RX_LOCKED),
  .cnt     (u_rx.cnt_q)
);

// File: tb/sim_sdac_loader.sv
`timescale 1ns/1ps
module sim_sdac_loader;

  logic       clk;
  logic       rst_n;
  logic       load_n, ser_clk, ser_dat, pwrdn_req;
  logic [9:0] code_o, obin_o;
  logic       upd_o, pwrdn_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [9:0] exp_q[$];
  logic [9:0] exp_code;
  bit         mon_en = 0;

  sdac_loader u0 (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .pwrdn_req(pwrdn_req), .code_o(code_o),
    .obin_o(obin_o), .upd_o(upd_o), .pwrdn_o(pwrdn_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One serial bit: data settles, then a rising and a falling serial edge.
  task automatic bit_edge(input logic b);
    ser_dat = b; tick(2);
    ser_clk = 1'b1; tick(4);
    ser_clk = 1'b0; tick(2);
  endtask

  // Ten bits LSB first; the expected word is queued before the last bit.
  task automatic shift_bits(input logic [9:0] w);
    for (int i = 0; i < 9; i++) bit_edge(w[i]);
    exp_q.push_back(w);
    exp_code = w;
    bit_edge(w[9]);
  endtask

  task automatic send_word(input logic [9:0] w, input int extra);
    load_n = 1'b0; tick(4);
    shift_bits(w);
    for (int e = 0; e < extra; e++) bit_edge(~w[e % 10]);
    tick(4);
    chk(code_o == exp_code, "R4 code after extra edges", code_o, exp_code);
    load_n = 1'b1; tick(6);
    chk(exp_q.size() == 0, "R2 word loaded", exp_q.size(), 0);
  endtask

  // Scoreboard monitor: every strobe must match the oldest queued word.
  initial begin
    forever begin
      @(negedge clk);
      if (mon_en && upd_o) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3/R4/R9 unexpected update", code_o, exp_code);
        end else begin
          logic [9:0] w;
          w = exp_q.pop_front();
          chk(code_o == w, "R2 latched code", code_o, w);
          chk(obin_o == (w ^ 10'h200), "R7 offset binary", obin_o, w ^ 10'h200);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_n = 1'b1; ser_clk = 1'b0; ser_dat = 1'b0; pwrdn_req = 1'b0;
    exp_code = 10'h000;
    tick(5);
    rst_n = 1'b1;
    tick(6);
    // R1: reset state
    chk(code_o == 10'h000, "R1 reset code", code_o, 0);
    chk(obin_o == 10'd512, "R1 reset offset", obin_o, 512);
    chk(upd_o == 1'b0, "R1 reset strobe", upd_o, 0);
    chk(pwrdn_o == 1'b0, "R8 reset status", pwrdn_o, 0);
    mon_en = 1;

    // R2/R7: several patterns incl. zero, full and one-below-mid scale
    send_word(10'h200, 0);
    send_word(10'h1FF, 0);
    send_word(10'h3FF, 0);
    send_word(10'h155, 0);
    send_word(10'h2AA, 0);

    // R4: extra edges after the tenth bit are ignored
    send_word(10'h0C3, 7);

    // R5: edges with select high do nothing
    load_n = 1'b1;
    for (int i = 0; i < 5; i++) bit_edge(1'b1);
    chk(code_o == exp_code, "R5 code held while deselected", code_o, exp_code);
    send_word(10'h301, 0);

    // R6: partial word discarded, next word counted from bit 0
    load_n = 1'b0; tick(4);
    for (int i = 0; i < 6; i++) bit_edge(1'b1);
    load_n = 1'b1; tick(6);
    chk(code_o == exp_code, "R6 partial word discarded", code_o, exp_code);
    send_word(10'h02D, 0);

    // R8: power-down does not block a load and is reported
    pwrdn_req = 1'b1; tick(3);
    chk(pwrdn_o == 1'b1, "R8 status high", pwrdn_o, 1);
    send_word(10'h111, 0);
    pwrdn_req = 1'b0; tick(3);
    chk(pwrdn_o == 1'b0, "R8 status low", pwrdn_o, 0);

    // R9: tenth edge and select release together: no load
    begin
      logic [9:0] w9;
      w9 = 10'h3C5;
      load_n = 1'b0; tick(4);
      for (int i = 0; i < 9; i++) bit_edge(w9[i]);
      ser_dat = w9[9]; tick(2);
      ser_clk = 1'b1; load_n = 1'b1; tick(4);
      ser_clk = 1'b0; tick(6);
      chk(code_o == exp_code, "R9 release wins over tenth edge", code_o, exp_code);
    end

    // R10: clock already high at select, falling edge does not shift
    ser_clk = 1'b1; tick(4);
    load_n = 1'b0; tick(4);
    ser_clk = 1'b0; tick(4);
    shift_bits(10'h25A);
    tick(4);
    load_n = 1'b1; tick(6);
    chk(code_o == 10'h25A, "R10 only rising edges shift", code_o, 10'h25A);
    chk(exp_q.size() == 0, "R10 word loaded", exp_q.size(), 0);

    // R7: mid scale maps to 512
    send_word(10'h000, 0);
    chk(obin_o == 10'd512, "R7 mid scale offset", obin_o, 512);

    tick(4);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule